// File: doc/BRIEF.md
# Linear-Count Display Timing Generator

This block produces horizontal sync, vertical sync and data-enable timing for an external display link. It runs on the pixel clock and is configured through a small register write port. Horizontal timing is a pixel count within a line, starting at the hsync leading edge. Vertical timing is not a line count. It is a single linear pixel count that spans the whole frame from the start of vsync. The frame length, the vsync pulse length and the vertical active window are therefore all programmed in pixels.

All timing settings are written into a shadow set. The generator copies the shadow set into its working set at a frame boundary, so a mode change written in the middle of a frame cannot tear that frame. Enabling starts a frame at position zero. Disabling lets the current frame finish and then stops. The boundary at which the generator stops is marked by the same strobe that marks each frame start. An underflow input from upstream does not alter timing. It only selects a programmable fill colour during active pixels, and only when recovery is turned on.

Top module: `lin_disp_timing`

## Requirements
- R1: While running, hsync is asserted for the first `pulse width` pixels of each line, and a line lasts `line period` pixels. Register 1 holds the line period in bits [15:0] and the pulse width in bits [31:16].
- R2: A frame lasts `frame total` pixels (register 2). Vsync is asserted for the first `vsync length` pixels of the frame (register 3).
- R3: Data enable is high when two conditions hold together. The line position must lie within [hstart, hend], both inclusive (register 4: start in [15:0], end in [31:16]). The frame position must lie within [vstart, vend], both inclusive (registers 5 and 6).
- R4: A skew value in pixels (register 7, bits [15:0], reset value 0) is added to both vertical window bounds.
- R5: Register 8 bit 0 makes hsync active low and bit 1 makes vsync active low. When a bit is clear, that output is active high.
- R6: The fill select output is high for an active pixel when underflow is high and recovery is on. Recovery is register 9 bit 24 and the fill colour is register 9 bits [23:0]; the colour is presented on its own output. Underflow never changes sync or data-enable timing.
- R7: A timing register written while running takes effect only from the next frame boundary.
- R8: Writing 0 to register 0 bit 0 lets the current frame run to its end. Output then stops, and the frame strobe pulses once at that boundary.
- R9: While stopped, both syncs sit at their inactive levels and data enable is low. After an enable, the first output cycle is frame position zero with both syncs asserted.
- R10: The frame strobe pulses for one cycle at the first pixel of every frame, so consecutive strobes are `frame total` cycles apart.
- R11: After reset all outputs are 0 and the generator is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Register write value |
| underflow_in | input | 1 | Upstream pixel underflow |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| fill_sel_o | output | 1 | Substitute fill colour for this pixel |
| fill_rgb_o | output | 24 | Fill colour in use |
| frame_start_o | output | 1 | Frame boundary strobe |

## Verification
The assertions assume that every mode in force while running is legal. The line period and frame total must be at least 1 and fit their fields, and the frame total must be a whole number of lines. If these assumptions fail, the checks that the line and frame counters stay below their limits lose their meaning. The stimulus only enables the generator after a full legal mode has been written. Later mode changes write legal values only, the window bounds lie inside the frame, and no other register indexes are written.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
  typedef enum logic [3:0] {
    RA_ENABLE = 4'd0,
    RA_HTIME  = 4'd1,
    RA_FTOTAL = 4'd2,
    RA_VLEN   = 4'd3,
    RA_HWIN   = 4'd4,
    RA_VSTART = 4'd5,
    RA_VEND   = 4'd6,
    RA_SKEW   = 4'd7,
    RA_POL    = 4'd8,
    RA_FILL   = 4'd9
  } reg_addr_e;

  localparam int unsigned HI_FIELD_LSB = 16;
  localparam int unsigned RECOVER_BIT  = 24;
endpackage

// File: rtl/ldt_regs.sv
module ldt_regs
  import ldt_pkg::*;
#(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          s_en,
  output logic [HW-1:0] s_hper,
  output logic [HW-1:0] s_hpw,
  output logic [FW-1:0] s_ftot,
  output logic [FW-1:0] s_vlen,
  output logic [HW-1:0] s_hs,
  output logic [HW-1:0] s_he,
  output logic [FW-1:0] s_vs,
  output logic [FW-1:0] s_ve,
  output logic [HW-1:0] s_skew,
  output logic [1:0]    s_pol,
  output logic          s_rec,
  output logic [CW-1:0] s_col
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_en   <= 1'b0;
      s_hper <= '0;
      s_hpw  <= '0;
      s_ftot <= '0;
      s_vlen <= '0;
      s_hs   <= '0;
      s_he   <= '0;
      s_vs   <= '0;
      s_ve   <= '0;
      s_skew <= '0;
      s_pol  <= '0;
      s_rec  <= 1'b0;
      s_col  <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_ENABLE: s_en <= wr_data[0];
        RA_HTIME: begin
          s_hper <= wr_data[HW-1:0];
          s_hpw  <= wr_data[HI_FIELD_LSB +: HW];
        end
        RA_FTOTAL: s_ftot <= wr_data[FW-1:0];
        RA_VLEN:   s_vlen <= wr_data[FW-1:0];
        RA_HWIN: begin
          s_hs <= wr_data[HW-1:0];
          s_he <= wr_data[HI_FIELD_LSB +: HW];
        end
        RA_VSTART: s_vs   <= wr_data[FW-1:0];
        RA_VEND:   s_ve   <= wr_data[FW-1:0];
        RA_SKEW:   s_skew <= wr_data[HW-1:0];
        RA_POL:    s_pol  <= wr_data[1:0];
        RA_FILL: begin
          s_col <= wr_data[CW-1:0];
          s_rec <= wr_data[RECOVER_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ldt_seq.sv
module ldt_seq #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_en,
  input  logic [HW-1:0] s_hper,
  input  logic [HW-1:0] s_hpw,
  input  logic [FW-1:0] s_ftot,
  input  logic [FW-1:0] s_vlen,
  input  logic [HW-1:0] s_hs,
  input  logic [HW-1:0] s_he,
  input  logic [FW-1:0] s_vs,
  input  logic [FW-1:0] s_ve,
  input  logic [HW-1:0] s_skew,
  input  logic [1:0]    s_pol,
  input  logic          s_rec,
  input  logic [CW-1:0] s_col,
  output logic [HW-1:0] a_hpw,
  output logic [FW-1:0] a_vlen,
  output logic [HW-1:0] a_hs,
  output logic [HW-1:0] a_he,
  output logic [FW-1:0] a_vs,
  output logic [FW-1:0] a_ve,
  output logic [HW-1:0] a_skew,
  output logic [1:0]    a_pol,
  output logic          a_rec,
  output logic [CW-1:0] a_col,
  output logic          run,
  output logic [HW-1:0] hcnt,
  output logic [FW-1:0] fcnt,
  output logic          stop_evt
);
  logic [HW-1:0] a_hper;
  logic [FW-1:0] a_ftot;
  logic line_last, frame_last, load;

  assign line_last  = (hcnt == a_hper - HW'(1));
  assign frame_last = (fcnt == a_ftot - FW'(1));
  // Working set follows the shadow set while stopped, and at a boundary that continues
  assign load       = !run || (frame_last && s_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_hper <= '0; a_hpw <= '0; a_ftot <= '0; a_vlen <= '0;
      a_hs <= '0; a_he <= '0; a_vs <= '0; a_ve <= '0;
      a_skew <= '0; a_pol <= '0; a_rec <= 1'b0; a_col <= '0;
    end else if (load) begin
      a_hper <= s_hper; a_hpw <= s_hpw; a_ftot <= s_ftot; a_vlen <= s_vlen;
      a_hs <= s_hs; a_he <= s_he; a_vs <= s_vs; a_ve <= s_ve;
      a_skew <= s_skew; a_pol <= s_pol; a_rec <= s_rec; a_col <= s_col;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      hcnt     <= '0;
      fcnt     <= '0;
      stop_evt <= 1'b0;
    end else begin
      stop_evt <= 1'b0;
      if (!run) begin
        run  <= s_en;
        hcnt <= '0;
        fcnt <= '0;
      end else if (frame_last) begin
        hcnt <= '0;
        fcnt <= '0;
        if (!s_en) begin
          run      <= 1'b0;
          stop_evt <= 1'b1;
        end
      end else begin
        hcnt <= line_last ? '0 : hcnt + HW'(1);
        fcnt <= fcnt + FW'(1);
      end
    end
  end

  AST_HCNT_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    run |-> (hcnt < a_hper)); // R1
  AST_FCNT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    run |-> (fcnt < a_ftot)); // R2
  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> ($past(fcnt + FW'(1)) == $past(a_ftot))); // R8
  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |-> (hcnt == '0 && fcnt == '0)); // R9
endmodule

// File: rtl/ldt_out.sv
module ldt_out #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] hcnt,
  input  logic [FW-1:0] fcnt,
  input  logic          stop_evt,
  input  logic [HW-1:0] a_hpw,
  input  logic [FW-1:0] a_vlen,
  input  logic [HW-1:0] a_hs,
  input  logic [HW-1:0] a_he,
  input  logic [FW-1:0] a_vs,
  input  logic [FW-1:0] a_ve,
  input  logic [HW-1:0] a_skew,
  input  logic [1:0]    a_pol,
  input  logic          a_rec,
  input  logic [CW-1:0] a_col,
  input  logic          underflow_in,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          fill_sel_o,
  output logic [CW-1:0] fill_rgb_o,
  output logic          frame_start_o
);
  localparam int VW = FW + 1;

  logic [VW-1:0] v_lo, v_hi, f_ext;
  logic hs_on, vs_on, h_in, v_in, de_c;

  assign v_lo  = VW'(a_vs) + VW'(a_skew);
  assign v_hi  = VW'(a_ve) + VW'(a_skew);
  assign f_ext = VW'(fcnt);
  assign hs_on = run && (hcnt < a_hpw);
  assign vs_on = run && (fcnt < a_vlen);
  assign h_in  = (hcnt >= a_hs) && (hcnt <= a_he);
  assign v_in  = (f_ext >= v_lo) && (f_ext <= v_hi);
  assign de_c  = run && h_in && v_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      de_o          <= 1'b0;
      fill_sel_o    <= 1'b0;
      fill_rgb_o    <= '0;
      frame_start_o <= 1'b0;
    end else begin
      hsync_o       <= hs_on ^ a_pol[0];
      vsync_o       <= vs_on ^ a_pol[1];
      de_o          <= de_c;
      fill_sel_o    <= de_c && underflow_in && a_rec;
      fill_rgb_o    <= a_col;
      frame_start_o <= (run && fcnt == '0) || stop_evt;
    end
  end

  AST_DE_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> !de_o); // R9
  AST_FILL_NEEDS_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill_sel_o |-> $past(underflow_in)); // R6
endmodule

// File: rtl/lin_disp_timing.sv
module lin_disp_timing #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int CW = 24,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          underflow_in,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          fill_sel_o,
  output logic [CW-1:0] fill_rgb_o,
  output logic          frame_start_o
);
  logic          s_en, s_rec, a_rec, run, stop_evt;
  logic [HW-1:0] s_hper, s_hpw, s_hs, s_he, s_skew;
  logic [FW-1:0] s_ftot, s_vlen, s_vs, s_ve;
  logic [1:0]    s_pol, a_pol;
  logic [CW-1:0] s_col, a_col;
  logic [HW-1:0] a_hpw, a_hs, a_he, a_skew, hcnt;
  logic [FW-1:0] a_vlen, a_vs, a_ve, fcnt;

  ldt_regs #(.HW(HW), .FW(FW), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .s_en(s_en), .s_hper(s_hper), .s_hpw(s_hpw), .s_ftot(s_ftot), .s_vlen(s_vlen),
    .s_hs(s_hs), .s_he(s_he), .s_vs(s_vs), .s_ve(s_ve), .s_skew(s_skew),
    .s_pol(s_pol), .s_rec(s_rec), .s_col(s_col)
  );

  ldt_seq #(.HW(HW), .FW(FW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .s_en(s_en),
    .s_hper(s_hper), .s_hpw(s_hpw), .s_ftot(s_ftot), .s_vlen(s_vlen),
    .s_hs(s_hs), .s_he(s_he), .s_vs(s_vs), .s_ve(s_ve), .s_skew(s_skew),
    .s_pol(s_pol), .s_rec(s_rec), .s_col(s_col),
    .a_hpw(a_hpw), .a_vlen(a_vlen), .a_hs(a_hs), .a_he(a_he), .a_vs(a_vs),
    .a_ve(a_ve), .a_skew(a_skew), .a_pol(a_pol), .a_rec(a_rec), .a_col(a_col),
    .run(run), .hcnt(hcnt), .fcnt(fcnt), .stop_evt(stop_evt)
  );

  ldt_out #(.HW(HW), .FW(FW), .CW(CW)) u_out (
    .clk(clk), .rst(rst), .run(run), .hcnt(hcnt), .fcnt(fcnt), .stop_evt(stop_evt),
    .a_hpw(a_hpw), .a_vlen(a_vlen), .a_hs(a_hs), .a_he(a_he), .a_vs(a_vs),
    .a_ve(a_ve), .a_skew(a_skew), .a_pol(a_pol), .a_rec(a_rec), .a_col(a_col),
    .underflow_in(underflow_in),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .fill_sel_o(fill_sel_o),
    .fill_rgb_o(fill_rgb_o), .frame_start_o(frame_start_o)
  );
endmodule

// File: tb/tb_lin_disp_timing.sv
module tb_lin_disp_timing;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        underflow_in = 1'b0;
  logic        hsync_o, vsync_o, de_o, fill_sel_o, frame_start_o;
  logic [23:0] fill_rgb_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  lin_disp_timing dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .underflow_in(underflow_in), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .fill_sel_o(fill_sel_o), .fill_rgb_o(fill_rgb_o), .frame_start_o(frame_start_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] sh [10];
  logic [31:0] ac [10];
  bit m_run, m_stop;
  int m_h, m_f;
  bit e_hs, e_vs, e_de, e_fill, e_fs;
  int e_col;

  always @(posedge clk) begin
    if (rst) begin
      foreach (sh[i]) begin sh[i] = '0; ac[i] = '0; end
      m_run = 0; m_stop = 0; m_h = 0; m_f = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_fill = 0; e_fs = 0; e_col = 0;
    end else begin
      int hper, hpw, ftot, vlen, hs, he, vs, ve, sk;
      hper = ac[1][15:0]; hpw = ac[1][31:16]; ftot = ac[2]; vlen = ac[3];
      hs = ac[4][15:0]; he = ac[4][31:16]; vs = ac[5]; ve = ac[6]; sk = ac[7][15:0];
      e_hs   = (m_run && m_h < hpw) ^ ac[8][0];
      e_vs   = (m_run && m_f < vlen) ^ ac[8][1];
      e_de   = m_run && m_h >= hs && m_h <= he && m_f >= vs + sk && m_f <= ve + sk;
      e_fill = e_de && underflow_in && ac[9][24];
      e_col  = ac[9][23:0];
      e_fs   = (m_run && m_f == 0) || m_stop;
      m_stop = 0;
      if (!m_run) begin
        ac = sh;
        m_run = sh[0][0]; m_h = 0; m_f = 0;
      end else if (m_f == ftot - 1) begin
        m_h = 0; m_f = 0;
        if (sh[0][0]) ac = sh;
        else begin m_run = 0; m_stop = 1; end
      end else begin
        m_h = (m_h == hper - 1) ? 0 : m_h + 1;
        m_f = m_f + 1;
      end
      if (wr_en) sh[wr_addr] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(hsync_o == e_hs, "R1/R5", "hsync", hsync_o, e_hs);
      check(vsync_o == e_vs, "R2/R5", "vsync", vsync_o, e_vs);
      check(de_o == e_de, "R3/R4", "de", de_o, e_de);
      check(fill_sel_o == e_fill, "R6", "fill_sel", fill_sel_o, e_fill);
      check(fill_rgb_o == 24'(e_col), "R6", "fill_rgb", fill_rgb_o, e_col);
      check(frame_start_o == e_fs, "R10", "frame_start", frame_start_o, e_fs);
    end
  end

  // ---------------- helpers ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start_o);
  endtask

  // counts de and fill over one frame starting at a strobe; first de offset
  task automatic frame_stats(output int n_de, output int n_fill, output int first);
    n_de = 0; n_fill = 0; first = -1;
    wait_fs();
    for (int i = 0; i < 80; i++) begin
      if (de_o) begin
        if (first < 0) first = i;
        n_de++;
      end
      if (fill_sel_o) n_fill++;
      @(negedge clk);
    end
  endtask

  task automatic hs_width(input bit act_lvl, output int w);
    w = 0;
    while (hsync_o == act_lvl) begin w++; @(negedge clk); end
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int nde, nfill, first, w, gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(!hsync_o && !vsync_o && !de_o && !fill_sel_o && !frame_start_o && fill_rgb_o == 0,
          "R11", "outputs after reset", {hsync_o, vsync_o, de_o, fill_sel_o, frame_start_o}, 0);
    cmp_on = 1'b1;

    // mode: period 10, pulse 2, 8 lines (2 sync, 1 back, 4 active, 1 front)
    wr(1, {16'd2, 16'd10});
    wr(2, 32'd80);
    wr(3, 32'd20);
    wr(4, {16'd7, 16'd3});
    wr(5, 32'd30);
    wr(6, 32'd69);
    wr(9, 32'h01AB_CDEF);
    repeat (5) @(negedge clk);
    check(!de_o && !hsync_o && !vsync_o, "R9", "idle before enable", de_o, 0);
    wr(0, 32'd1);
    wait_fs();
    check(hsync_o && vsync_o, "R9", "syncs asserted at first pixel", {hsync_o, vsync_o}, 3);
    hs_width(1'b1, w);
    check(w == 2, "R1", "hsync width", w, 2);

    frame_stats(nde, nfill, first);
    check(nde == 20, "R3", "de per frame", nde, 20);
    check(first == 33, "R3", "first de offset", first, 33);

    // R10: strobe spacing
    gap = 0;
    do begin @(negedge clk); gap++; end while (!frame_start_o);
    check(gap == 80, "R10", "strobe spacing", gap, 80);

    // R6: underflow with recovery
    underflow_in = 1'b1;
    frame_stats(nde, nfill, first);
    check(nfill == 20, "R6", "fill count with recovery", nfill, 20);
    check(nde == 20, "R6", "de unaffected by underflow", nde, 20);
    wr(9, 32'h0012_3456);
    frame_stats(nde, nfill, first);
    check(nfill == 0, "R6", "fill count without recovery", nfill, 0);
    check(fill_rgb_o == 24'h123456, "R6", "fill colour", fill_rgb_o, 24'h123456);
    underflow_in = 1'b0;

    // R4: skew shifts vertical window
    wr(7, 32'd5);
    frame_stats(nde, nfill, first);
    check(first == 35, "R4", "first de with skew", first, 35);
    check(nde == 20, "R4", "de count with skew", nde, 20);
    wr(7, 32'd0);

    // R7: mid-frame write applies at next boundary
    wait_fs();
    repeat (15) @(negedge clk);
    wr(1, {16'd4, 16'd10});
    while (hsync_o) @(negedge clk);
    while (!hsync_o) @(negedge clk);
    hs_width(1'b1, w);
    check(w == 2, "R7", "old width kept mid-frame", w, 2);
    wait_fs();
    hs_width(1'b1, w);
    check(w == 4, "R7", "new width at next frame", w, 4);

    // R5: polarity
    wr(8, 32'd3);
    wait_fs();
    check(!hsync_o && !vsync_o, "R5", "active-low syncs asserted", {hsync_o, vsync_o}, 0);

    // R8: disable mid-frame
    repeat (10) @(negedge clk);
    wr(0, 32'd0);
    gap = 12;
    do begin @(negedge clk); gap++; end while (!frame_start_o);
    check(gap == 80, "R8", "stop strobe at frame end", gap, 80);
    nde = 0; w = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (de_o) nde++;
      if (!hsync_o || !vsync_o || frame_start_o) w++;
    end
    check(nde == 0, "R9", "de low while stopped", nde, 0);
    check(w == 0, "R9", "syncs inactive (high) while stopped", w, 0);

    // re-enable, active high again
    wr(8, 32'd0);
    wr(0, 32'd1);
    wait_fs();
    check(hsync_o && vsync_o, "R9", "restart at position zero", {hsync_o, vsync_o}, 3);
    frame_stats(nde, nfill, first);
    check(nde == 20, "R3", "de after restart", nde, 20);

    repeat (20) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule